// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives words from an external master that supplies both the serial clock and the data line. Both lines are brought into the system clock domain through a short synchronizer. On each falling edge of the incoming clock, one data bit is captured, least significant bit first. A word is either 8 or 9 bits long. When the last bit arrives, the word moves into a holding register and a ready flag rises. The ready flag is gated by an enable input to form an interrupt request.

Software uses two byte-wide locations on a simple register bus. Location 0 is a control/status byte. Location 1 is the received data byte. In the control/status byte, bits 7 down to 3 are writable: port enable, nine-bit select, single-request, continuous enable and address-detect enable. Bits 2 down to 0 are read-only: framing error, overrun and the ninth received bit. Reading the data byte consumes the word. After an overrun, the block is blocked until software drops the continuous enable and sets it again.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, location 0 and location 1 both read 0x00, and `rx_ready` and `rx_irq` are low.
- R2: A bit is captured only when all of these hold: port enable (location 0, bit 7) is 1, continuous enable (bit 4) is 1, `sync_mode` is 1 and `master_sel` is 0. In every other case, incoming clock edges leave the flag and the data unchanged.
- R3: Bits are taken on falling edges of `ser_clk`, least significant bit first. With nine-bit select (bit 6) cleared, the 8th bit completes the word: it is copied to location 1 and `rx_ready` rises.
- R4: With nine-bit select set, the 9th bit completes the word. The low 8 bits go to location 1 and the top bit reads at location 0, bit 0. In 8-bit mode, bit 0 reads 0.
- R5: The single-request bit (location 0, bit 5) has no effect on reception. It neither starts a capture while continuous enable is 0 nor alters a capture while continuous enable is 1.
- R6: `rx_irq` is high exactly when `rx_ready` and `rx_int_en` are both high.
- R7: A read of location 1 clears `rx_ready` at the edge that ends the read cycle. A read of location 0 leaves it set.
- R8: If a word completes while `rx_ready` is still high, the overrun bit (location 0, bit 1) is set and location 1 keeps the older word. No further word completes while overrun is set.
- R9: Writing continuous enable to 0 clears overrun and discards any partly received word. The next word after re-enabling is assembled from its own bits only.
- R10: Writes to location 0 store bits 7..3 and ignore bits 2..0. The framing-error bit (bit 2) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock from the external master, idle high |
| ser_data | input | 1 | Serial data line |
| sync_mode | input | 1 | Synchronous mode selected for the port |
| master_sel | input | 1 | 1 = this side drives the clock (reception disabled) |
| rx_int_en | input | 1 | Receive interrupt enable |
| bus_addr | input | 1 | Register location: 0 control/status, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of location 1 consumes the word) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location, combinational |
| rx_ready | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A falling edge on `ser_clk` passes through two synchronizer flops and one edge-history flop. The bit it carries is therefore captured at the third system clock edge after the fall. On the last bit, the flag, the data byte, the ninth bit and any overrun update at that same edge. `rx_irq` follows the flag combinationally. Reads are sampled one nanosecond after the falling system edge, and the flag clear takes effect at the next rising edge. The bench holds every serial level for four system cycles and waits at least four more cycles before sampling any result, so each check falls after its result is due and before the next stimulus.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  // Register locations
  localparam logic LOC_STAT = 1'b0;
  localparam logic LOC_DATA = 1'b1;

  // Control/status byte bit positions
  localparam int B_PORT_EN = 7;
  localparam int B_NINE    = 6;
  localparam int B_SINGLE  = 5;
  localparam int B_CONT    = 4;
  localparam int B_ADET    = 3;
  localparam int B_FRAME   = 2;
  localparam int B_OVR     = 1;
  localparam int B_BIT8    = 0;

  // Number of writable bits at the top of the control/status byte
  localparam int CTL_BITS  = 5;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_async,
  input  logic sdat_async,
  output logic fall_evt,
  output logic sdat_sync
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            ck_q[0] <= 1'b1;
            dt_q[0] <= 1'b0;
          end else begin
            ck_q[0] <= sck_async;
            dt_q[0] <= sdat_async;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            ck_q[s] <= 1'b1;
            dt_q[s] <= 1'b0;
          end else begin
            ck_q[s] <= ck_q[s-1];
            dt_q[s] <= dt_q[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ck_prev <= 1'b1;
    else        ck_prev <= ck_q[STAGES-1];
  end

  assign fall_evt  = ck_prev & ~ck_q[STAGES-1];
  assign sdat_sync = dt_q[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int W  = 9,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          enable,
  input  logic          fall_evt,
  input  logic          din,
  input  logic          nine,
  output logic          word_done,
  output logic [W-1:0]  word,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST_SHORT = CW'(W - 2);
  localparam logic [CW-1:0] LAST_LONG  = CW'(W - 1);

  logic [W-1:0] sr;
  logic         take;

  // Place one bit at a given index of the partial word
  function automatic logic [W-1:0] put_bit(input logic [W-1:0] v,
                                           input logic [CW-1:0] idx,
                                           input logic b);
    logic [W-1:0] r;
    r = v;
    r[idx] = b;
    return r;
  endfunction

  function automatic logic [CW-1:0] last_index(input logic nine_sel);
    return nine_sel ? LAST_LONG : LAST_SHORT;
  endfunction

  assign take      = enable & fall_evt;
  assign word_done = take & (bit_cnt == last_index(nine));
  assign word      = put_bit(sr, bit_cnt, din);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (word_done) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      sr      <= word;
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import sync_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          word_done,
  input  logic [DW:0]   word,
  output logic          port_en,
  output logic          nine,
  output logic          cont_en,
  output logic          flag,
  output logic          overrun,
  output logic          rd_data_evt
);
  logic [CTL_BITS-1:0] ctl;
  logic [DW-1:0]       data_q;
  logic                bit8_q;

  assign port_en     = ctl[B_PORT_EN - B_ADET];
  assign nine        = ctl[B_NINE - B_ADET];
  assign cont_en     = ctl[B_CONT - B_ADET];
  assign rd_data_evt = bus_rd & (bus_addr == LOC_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      data_q  <= '0;
      bit8_q  <= 1'b0;
      flag    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == LOC_STAT)
        ctl <= bus_wdata[7:B_ADET];
      if (!cont_en)
        overrun <= 1'b0;
      else if (word_done && flag)
        overrun <= 1'b1;
      if (word_done && !flag) begin
        data_q <= word[DW-1:0];
        bit8_q <= nine & word[DW];
        flag   <= 1'b1;
      end else if (rd_data_evt) begin
        flag   <= 1'b0;
      end
    end
  end

  always_comb begin
    if (bus_addr == LOC_STAT)
      bus_rdata = {ctl, 1'b0, overrun, bit8_q};
    else
      bus_rdata = 8'(data_q);
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       sync_mode,
  input  logic       master_sel,
  input  logic       rx_int_en,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_ready,
  output logic       rx_irq
);
  localparam int WW = DATA_W + 1;
  localparam int CW = $clog2(WW + 1);

  logic          fall_evt, sdat_sync;
  logic          word_done;
  logic [WW-1:0] word;
  logic [CW-1:0] bit_cnt;
  logic          port_en, nine, cont_en, overrun, rd_data_evt;
  logic          rx_active, rx_clear;

  assign rx_active = port_en & cont_en & sync_mode & ~master_sel & ~overrun;
  assign rx_clear  = ~(port_en & cont_en);
  assign rx_irq    = rx_ready & rx_int_en;

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_async(ser_clk), .sdat_async(ser_data),
    .fall_evt(fall_evt), .sdat_sync(sdat_sync)
  );

  rx_shifter #(.W(WW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .enable(rx_active),
    .fall_evt(fall_evt), .din(sdat_sync), .nine(nine),
    .word_done(word_done), .word(word), .bit_cnt(bit_cnt)
  );

  rx_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_done(word_done), .word(word), .port_en(port_en), .nine(nine),
    .cont_en(cont_en), .flag(rx_ready), .overrun(overrun),
    .rd_data_evt(rd_data_evt)
  );
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_done,
  input logic          rx_ready,
  input logic          rx_irq,
  input logic          rx_int_en,
  input logic          rd_data_evt,
  input logic          overrun,
  input logic          cont_en,
  input logic          port_en,
  input logic          sync_mode,
  input logic          master_sel,
  input logic [CW-1:0] bit_cnt
);
  // R2
  gated_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (port_en && cont_en && sync_mode && !master_sel));
  // R3
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(word_done));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_int_en);
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !word_done) |=> !rx_ready);
  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_done && rx_ready));
  // R8
  overrun_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !word_done);
  // R9
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> (bit_cnt == '0));
endmodule

bind sync_slave_rx sync_slave_rx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_done(word_done), .rx_ready(rx_ready),
  .rx_irq(rx_irq), .rx_int_en(rx_int_en), .rd_data_evt(rd_data_evt),
  .overrun(overrun), .cont_en(cont_en), .port_en(port_en),
  .sync_mode(sync_mode), .master_sel(master_sel), .bit_cnt(bit_cnt)
);

// File: tb/sync_slave_rx_test.sv
`timescale 1ns/1ps
module sync_slave_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b1, ser_data = 1'b0;
  logic       sync_mode = 1'b1, master_sel = 1'b0, rx_int_en = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_ready, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  sync_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .sync_mode(sync_mode), .master_sel(master_sel), .rx_int_en(rx_int_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_loc(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_loc(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Falling-edge sampling, LSB first; each level held four cycles
  task automatic send(input logic [8:0] val, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      ser_data = val[k];
      tick(4);
      ser_clk = 1'b0;
      tick(4);
      ser_clk = 1'b1;
    end
    tick(6);
  endtask

  // Control byte values: port enable 0x80, nine-bit 0x40, single 0x20, continuous 0x10
  function automatic logic [7:0] stat_exp(input logic nine_m, input logic ovr,
                                          input logic b8);
    return 8'h90 | (nine_m ? 8'h40 : 8'h00) | (ovr ? 8'h02 : 8'h00)
           | ((nine_m & b8) ? 8'h01 : 8'h00);
  endfunction

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 ready", rx_ready, 0);
    check("R1 irq", rx_irq, 0);
    rd_loc(1'b0, v); check("R1 status", v, 8'h00);
    rd_loc(1'b1, v); check("R1 data", v, 8'h00);

    // R10 writable bits
    wr_loc(1'b0, 8'hFF);
    rd_loc(1'b0, v); check("R10 readback", v, 8'hF8);
    wr_loc(1'b0, 8'h07);
    rd_loc(1'b0, v); check("R10 low bits ignored", v, 8'h00);

    // R2 disabled configurations
    wr_loc(1'b0, 8'h80);                 // continuous off
    send(9'h0A5, 8); check("R2 cont off", rx_ready, 0);
    wr_loc(1'b0, 8'h10);                 // port off
    send(9'h0A5, 8); check("R2 port off", rx_ready, 0);
    wr_loc(1'b0, 8'h90);
    sync_mode = 1'b0;
    send(9'h0A5, 8); check("R2 async mode", rx_ready, 0);
    sync_mode = 1'b1; master_sel = 1'b1;
    send(9'h0A5, 8); check("R2 master clock", rx_ready, 0);
    master_sel = 1'b0;
    rd_loc(1'b1, v); check("R2 data untouched", v, 8'h00);

    // R5 single-request alone does nothing
    wr_loc(1'b0, 8'hA0);
    send(9'h05A, 8); check("R5 single no start", rx_ready, 0);

    // R3 8-bit sweep with R6 and R7
    wr_loc(1'b0, 8'h90);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] val;
      val = 8'((i * 37 + 11) & 255);
      if (i == 22) val = 8'h00;
      if (i == 23) val = 8'hFF;
      rx_int_en = i[0];
      send({1'b1, val}, 8);
      check("R3 ready", rx_ready, 1);
      check("R6 irq", rx_irq, i[0]);
      rd_loc(1'b0, v); check("R7 status read keeps flag", rx_ready, 1);
      check("R4 bit0 zero in 8-bit", v, stat_exp(1'b0, 1'b0, 1'b0));
      rd_loc(1'b1, v); check("R3 data", v, val);
      check("R7 cleared", rx_ready, 0);
      check("R6 irq low", rx_irq, 0);
    end
    rx_int_en = 1'b0;

    // R5 single-request set during reception
    wr_loc(1'b0, 8'hB0);
    send(9'h0C3, 8);
    rd_loc(1'b1, v); check("R5 single with cont", v, 8'hC3);

    // R4 9-bit sweep
    wr_loc(1'b0, 8'hD0);
    for (int i = 0; i < 16; i++) begin
      logic [8:0] val;
      val = 9'((i * 71 + 5) & 511);
      send(val, 9);
      check("R4 ready", rx_ready, 1);
      rd_loc(1'b0, v); check("R4 ninth bit", v, stat_exp(1'b1, 1'b0, val[8]));
      rd_loc(1'b1, v); check("R4 data", v, val[7:0]);
    end

    // R8 overrun
    wr_loc(1'b0, 8'h90);
    send(9'h011, 8);
    send(9'h022, 8);
    check("R8 flag held", rx_ready, 1);
    rd_loc(1'b0, v); check("R8 overrun bit", v, stat_exp(1'b0, 1'b1, 1'b0));
    rd_loc(1'b1, v); check("R8 old word kept", v, 8'h11);
    send(9'h033, 8);
    check("R8 blocked", rx_ready, 0);

    // R9 recovery and partial discard
    wr_loc(1'b0, 8'h80);
    rd_loc(1'b0, v); check("R9 overrun cleared", v, 8'h80);
    wr_loc(1'b0, 8'h90);
    send(9'h1FF, 3);
    wr_loc(1'b0, 8'h80);
    wr_loc(1'b0, 8'h90);
    send(9'h04C, 8);
    check("R9 ready", rx_ready, 1);
    rd_loc(1'b1, v); check("R9 fresh word", v, 8'h4C);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule